// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a single register meant to sit on a datapath between two pieces of combinational logic. A 2-bit select chooses one of four behaviours. In the first, it is an ordinary pipeline register. In the second, it is a serial shift chain for scan access. In the third, it free-runs as a pseudo-random pattern source. In the fourth, it folds each parallel word it observes into a running signature.

A typical self-test places one copy ahead of a logic cone in generator behaviour and a second copy after it in signature behaviour. After a fixed number of clocks the second copy holds one word. That word is then compared with a known-good value elsewhere.

The behaviour select acts as the state of the block. The four states are HOLD (code 00, parallel load), SHIFT (01, scan), PRPG (10, pattern generation) and MISR (11, signature compaction). Every transition between them is a direct change of the select input. Each transition keeps the register contents, and the new behaviour applies from the next rising clock edge. Two controls override the select: a synchronous reset and a seed load.

Top module: `selftest_reg`

## Requirements
- R1: A synchronous reset clears the whole register to zero and drives the scan output low on the next rising edge; reset takes priority over the seed load and over every mode.
- R2: With select 00 and no reset or seed load, the register takes the parallel input on every rising edge.
- R3: With select 01, each rising edge shifts the register one place toward the most significant bit, with the scan input entering bit 0.
- R4: With select 10 starting from the seed, the register steps as a left-shifting linear feedback register whose new bit 0 is the XOR of the bits selected by a maximal-length polynomial (at 8 bits x^8+x^6+x^5+x^4+1, that is bits 7, 5, 4 and 3). It visits 255 distinct states before it returns to the seed.
- R5: With select 10, a register holding all zeros reloads the seed on the next edge instead of locking up.
- R6: With select 11, the next value is the R4 shift-with-feedback of the current value XORed bitwise with the parallel input, so that a single-bit change in any observed word changes the final signature.
- R7: With the seed load high and reset low, the register takes the seed parameter value (default 1) on the next edge, whatever the select.
- R8: A change of select keeps the present register contents; the newly selected behaviour acts on those contents at the next edge.
- R9: The scan output always equals the most significant bit of the register, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Behaviour select: 00 HOLD, 01 SHIFT, 10 PRPG, 11 MISR |
| par_in | input | WIDTH | Parallel data / observed response word |
| scan_in | input | 1 | Serial input, enters bit 0 in SHIFT |
| init | input | 1 | Seed load, active high |
| par_out | output | WIDTH | Present register value |
| scan_out | output | 1 | Most significant register bit |

## Verification
Every result of this block appears exactly one rising edge after the inputs that cause it, because the register is the only storage between the ports. The bench drives each stimulus on a falling edge and holds it across the next rising edge. At that point it queues the value it predicts. A monitor then takes the expected item from the queue one time unit after that rising edge and compares it with the outputs. The full-period and signature-sensitivity checks read the outputs on the falling edge that follows their last step, which is the same one-edge latency.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHIFT = 2'b01,
        MODE_PRPG  = 2'b10,
        MODE_MISR  = 2'b11
    } mode_e;

    // Feedback masks for a left-shifting register: bit k set means
    // register bit k feeds the XOR that forms the new bit 0.
    function automatic logic [31:0] tap_mask(input int width);
        logic [31:0] m;
        case (width)
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0829;
            13:      m = 32'h0000_100D;
            14:      m = 32'h0000_2015;
            15:      m = 32'h0000_6000;
            16:      m = 32'h0000_D008;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stf_feedback.sv
module stf_feedback #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    TAPS = '0
) (
    input  logic [W-1:0] cur,
    output logic         fb
);
    always_comb begin
        fb = ^(cur & TAPS);
    end
endmodule

// File: rtl/stf_next.sv
module stf_next #(
    parameter int           W    = 8,
    parameter logic [W-1:0] SEED = 1
) (
    input  selftest_pkg::mode_e mode,
    input  logic                rst,
    input  logic                init,
    input  logic [W-1:0]        cur,
    input  logic [W-1:0]        d,
    input  logic                si,
    input  logic                fb,
    output logic [W-1:0]        nxt
);
    import selftest_pkg::*;

    logic [W-1:0] shifted_fb;
    logic [W-1:0] shifted_si;

    always_comb begin
        shifted_fb = {cur[W-2:0], fb};
        shifted_si = {cur[W-2:0], si};
    end

    always_comb begin
        if (rst) begin
            nxt = '0;
        end else if (init) begin
            nxt = SEED;
        end else begin
            unique case (mode)
                MODE_HOLD:  nxt = d;
                MODE_SHIFT: nxt = shifted_si;
                MODE_PRPG:  nxt = (cur == '0) ? SEED : shifted_fb;
                MODE_MISR:  nxt = shifted_fb ^ d;
                default:    nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    input  logic             init,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    import selftest_pkg::*;

    localparam logic [31:0]      MASK32 = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS   = MASK32[WIDTH-1:0];

    mode_e            mode_sel;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             fb_bit;

    always_comb begin
        mode_sel = mode_e'(mode);
    end

    stf_feedback #(.W(WIDTH), .TAPS(TAPS)) u_fb (
        .cur (state_q),
        .fb  (fb_bit)
    );

    stf_next #(.W(WIDTH), .SEED(SEED)) u_next (
        .mode (mode_sel),
        .rst  (rst),
        .init (init),
        .cur  (state_q),
        .d    (par_in),
        .si   (scan_in),
        .fb   (fb_bit),
        .nxt  (state_d)
    );

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // outputs
    always_comb begin
        par_out  = state_q;
        scan_out = state_q[WIDTH-1];
    end
endmodule

// File: rtl/selftest_reg_chk.sv
module selftest_reg_chk #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic             init,
    input logic [WIDTH-1:0] par_out,
    input logic             scan_out
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (par_out == '0 && scan_out == 1'b0));

    p_hold_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (!init && mode == 2'b00) |=> par_out == $past(par_in));

    p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (!init && mode == 2'b01) |=> par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)});

    p_shift_serial_out_r9: assert property (@(posedge clk) disable iff (rst)
        (!init && mode == 2'b01) |=> scan_out == $past(par_out[WIDTH-2]));

    p_prpg_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (!init && mode == 2'b10) |=> par_out != '0);

    p_seed_load_r7: assert property (@(posedge clk) disable iff (rst)
        init |=> par_out == SEED);
endmodule

bind selftest_reg selftest_reg_chk #(.WIDTH(WIDTH), .SEED(SEED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .init     (init),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/test_selftest_reg.sv
`timescale 1ns/1ps
module test_selftest_reg;
    localparam int        W    = 8;
    localparam logic [7:0] SEED = 8'h01;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [7:0] par_in = '0;
    logic       scan_in = 1'b0;
    logic       init = 1'b0;
    logic [7:0] par_out;
    logic       scan_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] q;
        logic       so;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [7:0] mdl = '0;

    always #2.5 clk = ~clk;

    selftest_reg #(.WIDTH(W), .SEED(SEED)) i_selftest_reg (
        .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
        .scan_in(scan_in), .init(init), .par_out(par_out), .scan_out(scan_out)
    );

    // Reference register for x^8+x^6+x^5+x^4+1, shifting left
    function automatic logic [7:0] ref_lfsr(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: called just after a falling edge; holds inputs over the next
    // rising edge and returns at the following falling edge.
    task automatic step(input logic r, input logic ini, input logic [1:0] m,
                        input logic [7:0] d, input logic s, input string tag);
        exp_t e;
        rst = r; init = ini; mode = m; par_in = d; scan_in = s;
        if (r)             mdl = '0;
        else if (ini)      mdl = SEED;
        else case (m)
            2'b00: mdl = d;
            2'b01: mdl = {mdl[6:0], s};
            2'b10: mdl = (mdl == 8'h00) ? SEED : ref_lfsr(mdl);
            default: mdl = ref_lfsr(mdl) ^ d;
        endcase
        e.q = mdl; e.so = mdl[7]; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, par_out, e.q);
            chk({e.tag, " scan_out R9"}, {7'b0, scan_out}, {7'b0, e.so});
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    logic [7:0] sig_a, sig_b;

    task automatic run_sig(input bit flip);
        step(1'b0, 1'b1, 2'b11, 8'h00, 1'b0, "R7 seed before MISR");
        for (int i = 0; i < 12; i++) begin
            logic [7:0] d;
            d = 8'(i * 37 + 5);
            if (flip && i == 4) d[3] = ~d[3];
            step(1'b0, 1'b0, 2'b11, d, 1'b0, "R6 MISR step");
        end
    endtask

    initial begin
        @(negedge clk);
        // R1 reset, including reset over seed load
        step(1'b1, 1'b0, 2'b00, 8'hFF, 1'b1, "R1 reset");
        step(1'b1, 1'b1, 2'b10, 8'hFF, 1'b1, "R1 reset beats seed");

        // R2 parallel load, several patterns
        step(1'b0, 1'b0, 2'b00, 8'hA5, 1'b0, "R2 hold load A5");
        step(1'b0, 1'b0, 2'b00, 8'h5A, 1'b0, "R2 hold load 5A");
        step(1'b0, 1'b0, 2'b00, 8'hFF, 1'b0, "R2 hold load FF");
        step(1'b0, 1'b0, 2'b00, 8'h80, 1'b0, "R2 hold load 80");

        // R8 switch HOLD->SHIFT keeps contents (80 shifts to 01)
        step(1'b0, 1'b0, 2'b01, 8'h00, 1'b1, "R8 mode change keeps contents");
        // R3 shift a byte through, scan_out watched by the monitor (R9)
        for (int i = 0; i < 8; i++)
            step(1'b0, 1'b0, 2'b01, 8'hFF, 1'((8'hC6 >> i) & 1), "R3 scan shift");
        chk("R3 serial byte captured", par_out, 8'h63);

        // R7 seed load in HOLD mode
        step(1'b0, 1'b1, 2'b00, 8'hEE, 1'b0, "R7 seed over hold");

        // R5 zero escape: load zero, then generator
        step(1'b0, 1'b0, 2'b00, 8'h00, 1'b0, "R5 load zero");
        step(1'b0, 1'b0, 2'b10, 8'h00, 1'b0, "R5 zero reloads seed");
        chk("R5 escaped to seed", par_out, SEED);

        // R4 full period from the seed
        begin
            bit seen [256];
            int early = 0;
            for (int i = 0; i < 256; i++) seen[i] = 1'b0;
            step(1'b0, 1'b1, 2'b10, 8'h00, 1'b0, "R7 seed before PRPG");
            for (int i = 0; i < 255; i++) begin
                if (seen[par_out]) early++;
                seen[par_out] = 1'b1;
                step(1'b0, 1'b0, 2'b10, 8'h3C, 1'b0, "R4 PRPG step");
            end
            chk("R4 period returns to seed", par_out, SEED);
            chk("R4 no early repeat", 8'(early), 8'd0);
        end

        // R8 switch PRPG->HOLD->MISR keeps contents
        step(1'b0, 1'b0, 2'b00, 8'h99, 1'b0, "R8 back to hold");
        step(1'b0, 1'b0, 2'b11, 8'h0F, 1'b0, "R8 hold to MISR keeps contents");

        // R6 signature sensitivity to a single-bit change
        run_sig(1'b0);
        sig_a = par_out;
        run_sig(1'b1);
        sig_b = par_out;
        checks++;
        if (sig_a == sig_b) begin
            errors++;
            $display("FAIL R6 signature unchanged by bit flip: actual %02h expected not %02h", sig_b, sig_a);
        end

        step(1'b1, 1'b0, 2'b11, 8'hFF, 1'b1, "R1 final reset");
        #2;
        summary();
    end
endmodule